// File: doc/BRIEF.md
# Bus Control Set/Clear Instruction Executor

This block executes the set/clear control instruction of a small script-driven bus controller. Each instruction arrives as two 32-bit words with a one-cycle valid strobe. The first word carries one operation bit that chooses between asserting and deasserting, plus three independent flag bits. These flags select the device role (target or initiator), the ACK line and the ATN line. The block keeps a mode register and a control-signal latch. It drives ACK and ATN onto the bus only while the device acts as initiator or while a loopback override is on.

The second word gives the address to fetch next if a selection or reselection fails. An addressing-mode input selects how that address is formed. In absolute mode it is taken as is. In relative mode its low 24 bits are a signed offset added to the current script pointer. The result comes out with a one-cycle valid strobe, alongside a done pulse for the instruction.

Top module: `busctl_setclr_exec`

## Requirements
- R1: After a synchronous reset, the mode register and the control latch are all zero, which means initiator role with ACK and ATN deasserted. done, addr_valid, bus_ack and bus_atn are low.
- R2: An instruction whose operation bit (word0 bit 27) is 1 and whose role flag (word0 bit 9) is 1 sets mode register bit 0 to 1, which is target role.
- R3: An instruction whose operation bit (word0 bit 27) is 0 and whose role flag (word0 bit 9) is 1 clears mode register bit 0 to 0, which is initiator role.
- R4: word0 bit 6 selects ACK and word0 bit 3 selects ATN. These are held in control latch bits 6 and 3 respectively. A set operation drives a selected latch bit to 1 and a clear operation drives it to 0.
- R5: Latch bits and the mode bit whose flag is 0 keep their values. The reserved bits 8:7, 5:4 and 2:0 of word0 have no effect.
- R6: bus_ack equals latch bit 6 and bus_atn equals latch bit 3 while mode bit 0 is 0 or loopback_en is 1. Otherwise both bus outputs are 0.
- R7: With rel_mode low, next_addr equals word1.
- R8: With rel_mode high, next_addr equals script_ptr plus the sign-extended word1[23:0], modulo 2^32. word1[31:24] is ignored.
- R9: Registers update at the clock edge that samples instr_valid. done and addr_valid are high for exactly the one cycle that follows such an edge.
- R10: Instructions on consecutive cycles take effect in issue order. For example, a set of ATN followed at once by a clear of ACK leaves ATN asserted and ACK deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction words present this cycle |
| instr_w0 | input | 32 | First instruction word: operation and flags |
| instr_w1 | input | 32 | Second instruction word: fallback address or offset |
| rel_mode | input | 1 | 1 selects relative addressing |
| script_ptr | input | 32 | Current script pointer |
| loopback_en | input | 1 | Lets ACK/ATN reach the bus in target role |
| done | output | 1 | One-cycle completion pulse |
| mode_reg | output | 8 | Mode control register, bit 0 = target role |
| ctl_latch | output | 8 | Control-signal latch, bit 6 ACK, bit 3 ATN |
| bus_ack | output | 1 | Gated ACK bus drive |
| bus_atn | output | 1 | Gated ATN bus drive |
| next_addr | output | 32 | Fallback fetch address |
| addr_valid | output | 1 | One-cycle strobe for next_addr |

## Verification
A single instruction can change the role and a control line in the same cycle. One example is a set that carries the role flag and the ACK flag together. Here the latch must show ACK set while the pin gate already uses the new target role, so bus_ack stays low. The bench provokes this with a combined-flag instruction and checks the latch and the pin in the same sampling slot. It then checks the reverse: a clear of the role flag makes the held ACK appear on the pin. Back-to-back instructions are judged cycle by cycle to show that each one lands in order.

// File: rtl/busctl_pkg.sv
package busctl_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OP_BIT   = 27;
    localparam int unsigned ROLE_BIT = 9;
    localparam int unsigned ACK_BIT  = 6;
    localparam int unsigned ATN_BIT  = 3;

    localparam int unsigned MODE_W   = 8;
    localparam int unsigned ROLE_POS = 0;
    localparam int unsigned LATCH_W  = 8;
    localparam int unsigned ACK_POS  = 6;
    localparam int unsigned ATN_POS  = 3;

    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_SET   = 1'b1
    } setclr_op_e;

    typedef struct packed {
        setclr_op_e op;
        logic       role_sel;
        logic       ack_sel;
        logic       atn_sel;
    } setclr_cmd_t;

    function automatic setclr_cmd_t decode_w0(input logic [WORD_W-1:0] w);
        setclr_cmd_t c;
        c.op       = setclr_op_e'(w[OP_BIT]);
        c.role_sel = w[ROLE_BIT];
        c.ack_sel  = w[ACK_BIT];
        c.atn_sel  = w[ATN_BIT];
        return c;
    endfunction

    function automatic logic apply_op(input setclr_op_e op,
                                      input logic sel,
                                      input logic cur);
        if (!sel) return cur;
        return (op == OP_SET);
    endfunction

endpackage

// File: rtl/busctl_decode.sv
module busctl_decode
    import busctl_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] w0,
    output logic              cmd_valid,
    output setclr_cmd_t       cmd
);
    setclr_cmd_t raw;
    logic        unused_w0;

    always_comb begin
        raw = decode_w0(w0);
        cmd_valid = valid;
        cmd = valid ? raw : '0;
    end

    assign unused_w0 = ^{w0[WORD_W-1:OP_BIT+1], w0[OP_BIT-1:ROLE_BIT+1],
                         w0[ROLE_BIT-1:ACK_BIT+1], w0[ACK_BIT-1:ATN_BIT+1],
                         w0[ATN_BIT-1:0]};
endmodule

// File: rtl/busctl_regs.sv
module busctl_regs
    import busctl_pkg::*;
#(
    parameter int unsigned MW = MODE_W,
    parameter int unsigned LW = LATCH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  setclr_cmd_t   cmd,
    output logic [MW-1:0] mode_q,
    output logic [LW-1:0] latch_q
);
    logic [LW-1:0] sel_mask;
    logic [LW-1:0] latch_d;
    logic [MW-1:0] mode_d;

    for (genvar i = 0; i < LW; i++) begin : g_mask
        if (i == ACK_POS) begin : g_ack
            assign sel_mask[i] = cmd.ack_sel;
        end else if (i == ATN_POS) begin : g_atn
            assign sel_mask[i] = cmd.atn_sel;
        end else begin : g_none
            assign sel_mask[i] = 1'b0;
        end
        assign latch_d[i] = apply_op(cmd.op, sel_mask[i], latch_q[i]);
    end

    for (genvar j = 0; j < MW; j++) begin : g_mode
        if (j == ROLE_POS) begin : g_role
            assign mode_d[j] = apply_op(cmd.op, cmd.role_sel, mode_q[j]);
        end else begin : g_hold
            assign mode_d[j] = mode_q[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            latch_q <= '0;
        end else if (cmd_valid) begin
            mode_q  <= mode_d;
            latch_q <= latch_d;
        end
    end
endmodule

// File: rtl/busctl_addr.sv
module busctl_addr #(
    parameter int unsigned AW   = 32,
    parameter int unsigned OFSW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          rel,
    input  logic [AW-1:0] w1,
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] addr_q,
    output logic          addr_vld_q,
    output logic          done_q
);
    localparam int unsigned EXT_W = AW - OFSW;

    logic [AW-1:0] ofs_ext;
    logic [AW-1:0] addr_d;

    assign ofs_ext = {{EXT_W{w1[OFSW-1]}}, w1[OFSW-1:0]};
    assign addr_d  = rel ? (ptr + ofs_ext) : w1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            addr_vld_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            addr_vld_q <= valid;
            done_q     <= valid;
            if (valid) addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/busctl_pin_gate.sv
module busctl_pin_gate
    import busctl_pkg::*;
(
    input  logic [MODE_W-1:0]  mode,
    input  logic [LATCH_W-1:0] latch,
    input  logic               loopback,
    output logic               ack_pin,
    output logic               atn_pin
);
    logic drive_ok;

    always_comb begin
        drive_ok = !mode[ROLE_POS] || loopback;
        ack_pin  = drive_ok && latch[ACK_POS];
        atn_pin  = drive_ok && latch[ATN_POS];
    end
endmodule

// File: rtl/busctl_setclr_exec.sv
module busctl_setclr_exec
    import busctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [WORD_W-1:0]   instr_w0,
    input  logic [ADDR_W-1:0]   instr_w1,
    input  logic                rel_mode,
    input  logic [ADDR_W-1:0]   script_ptr,
    input  logic                loopback_en,
    output logic                done,
    output logic [MODE_W-1:0]   mode_reg,
    output logic [LATCH_W-1:0]  ctl_latch,
    output logic                bus_ack,
    output logic                bus_atn,
    output logic [ADDR_W-1:0]   next_addr,
    output logic                addr_valid
);
    logic        cmd_valid;
    setclr_cmd_t cmd;

    busctl_decode u_dec (
        .valid     (instr_valid),
        .w0        (instr_w0),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    busctl_regs #(.MW(MODE_W), .LW(LATCH_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .mode_q    (mode_reg),
        .latch_q   (ctl_latch)
    );

    busctl_pin_gate u_gate (
        .mode     (mode_reg),
        .latch    (ctl_latch),
        .loopback (loopback_en),
        .ack_pin  (bus_ack),
        .atn_pin  (bus_atn)
    );

    busctl_addr #(.AW(ADDR_W), .OFSW(OFS_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .valid      (instr_valid),
        .rel        (rel_mode),
        .w1         (instr_w1),
        .ptr        (script_ptr),
        .addr_q     (next_addr),
        .addr_vld_q (addr_valid),
        .done_q     (done)
    );
endmodule

// File: rtl/busctl_setclr_chk.sv
module busctl_setclr_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [31:0] instr_w0,
    input logic [31:0] instr_w1,
    input logic        rel_mode,
    input logic [31:0] script_ptr,
    input logic        loopback_en,
    input logic        done,
    input logic [7:0]  mode_reg,
    input logic [7:0]  ctl_latch,
    input logic        bus_ack,
    input logic        bus_atn,
    input logic [31:0] next_addr,
    input logic        addr_valid
);
    a_r2_set_role: assert property (@(posedge clk) disable iff (rst)
        instr_valid && instr_w0[27] && instr_w0[9] |=> mode_reg[0]);

    a_r3_clear_role: assert property (@(posedge clk) disable iff (rst)
        instr_valid && !instr_w0[27] && instr_w0[9] |=> !mode_reg[0]);

    a_r4_set_atn: assert property (@(posedge clk) disable iff (rst)
        instr_valid && instr_w0[27] && instr_w0[3] |=> ctl_latch[3]);

    a_r5_ack_kept: assert property (@(posedge clk) disable iff (rst)
        instr_valid && !instr_w0[6] |=> $stable(ctl_latch[6]));

    a_r5_idle_kept: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(ctl_latch) && $stable(mode_reg));

    a_r6_pins_gated: assert property (@(posedge clk) disable iff (rst)
        mode_reg[0] && !loopback_en |-> !bus_ack && !bus_atn);

    a_r7_abs_addr: assert property (@(posedge clk) disable iff (rst)
        instr_valid && !rel_mode |=> next_addr == $past(instr_w1));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> done && addr_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !done && !addr_valid);
endmodule

bind busctl_setclr_exec busctl_setclr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_w0    (instr_w0),
    .instr_w1    (instr_w1),
    .rel_mode    (rel_mode),
    .script_ptr  (script_ptr),
    .loopback_en (loopback_en),
    .done        (done),
    .mode_reg    (mode_reg),
    .ctl_latch   (ctl_latch),
    .bus_ack     (bus_ack),
    .bus_atn     (bus_atn),
    .next_addr   (next_addr),
    .addr_valid  (addr_valid)
);

// File: tb/busctl_setclr_exec_tb.sv
`timescale 1ns/1ps
module busctl_setclr_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] instr_w0;
    logic [31:0] instr_w1;
    logic        rel_mode;
    logic [31:0] script_ptr;
    logic        loopback_en;
    logic        done;
    logic [7:0]  mode_reg;
    logic [7:0]  ctl_latch;
    logic        bus_ack;
    logic        bus_atn;
    logic [31:0] next_addr;
    logic        addr_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    busctl_setclr_exec dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_w0(instr_w0),
        .instr_w1(instr_w1), .rel_mode(rel_mode), .script_ptr(script_ptr),
        .loopback_en(loopback_en), .done(done), .mode_reg(mode_reg),
        .ctl_latch(ctl_latch), .bus_ack(bus_ack), .bus_atn(bus_atn),
        .next_addr(next_addr), .addr_valid(addr_valid)
    );

    // independent model of the architectural state
    logic m_role, m_ack, m_atn;

    function automatic logic [31:0] mk(input logic set, input logic role,
                                       input logic ack, input logic atn,
                                       input logic resv);
        logic [31:0] w = 32'h0;
        w[27] = set; w[9] = role; w[6] = ack; w[3] = atn;
        if (resv) begin
            w[8] = 1'b1; w[7] = 1'b1; w[5] = 1'b1; w[4] = 1'b1;
            w[2] = 1'b1; w[1] = 1'b1; w[0] = 1'b1;
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_apply(input logic [31:0] w);
        logic s = w[27];
        if (w[9]) m_role = s;
        if (w[6]) m_ack  = s;
        if (w[3]) m_atn  = s;
    endtask

    task automatic check_state(input string req);
        logic gate = !m_role || loopback_en;
        chk({req, " mode"},  {24'h0, mode_reg},  {31'h0, m_role});
        chk({req, " latch"}, {24'h0, ctl_latch}, {24'h0, 1'b0, m_ack, 2'b0, m_atn, 3'b0});
        chk({req, " pins R6"}, {30'h0, bus_ack, bus_atn},
            {30'h0, m_ack & gate, m_atn & gate});
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic issue(input logic [31:0] w0, input logic [31:0] w1,
                         input logic rel, input logic [31:0] ptr,
                         input string req);
        instr_valid = 1'b1; instr_w0 = w0; instr_w1 = w1;
        rel_mode = rel; script_ptr = ptr;
        @(negedge clk);
        instr_valid = 1'b0;
        model_apply(w0);
        chk({req, " done R9"}, {31'h0, done}, 32'h1);
        chk({req, " addr_valid R9"}, {31'h0, addr_valid}, 32'h1);
        check_state(req);
    endtask

    task automatic t_reset;
        chk("R1 mode", {24'h0, mode_reg}, 32'h0);
        chk("R1 latch", {24'h0, ctl_latch}, 32'h0);
        chk("R1 pins", {30'h0, bus_ack, bus_atn}, 32'h0);
        chk("R1 done", {30'h0, done, addr_valid}, 32'h0);
    endtask

    task automatic t_assert_both;
        issue(mk(1, 0, 1, 1, 0), 32'h0, 1'b0, 32'h0, "R4 set ack+atn");
        @(negedge clk);
        chk("R9 done drops", {30'h0, done, addr_valid}, 32'h0);
        check_state("R9 idle hold");
    endtask

    task automatic t_reserved;
        issue(mk(0, 0, 0, 0, 1), 32'h0, 1'b0, 32'h0, "R5 clear reserved");
        issue(mk(1, 0, 0, 0, 1), 32'h0, 1'b0, 32'h0, "R5 set reserved");
        chk("R5 latch intact", {24'h0, ctl_latch}, 32'h48);
    endtask

    task automatic t_clear_ack;
        issue(mk(0, 0, 1, 0, 0), 32'h0, 1'b0, 32'h0, "R4 clear ack");
        chk("R5 atn kept", {31'h0, bus_atn}, 32'h1);
        chk("R4 ack pin off", {31'h0, bus_ack}, 32'h0);
    endtask

    task automatic t_role;
        issue(mk(1, 1, 1, 0, 0), 32'h0, 1'b0, 32'h0, "R2 set role+ack");
        chk("R6 ack gated in target", {30'h0, bus_ack, bus_atn}, 32'h0);
        chk("R4 ack latched", {31'h0, ctl_latch[6]}, 32'h1);
        loopback_en = 1'b1;
        #1;
        chk("R6 loopback opens", {30'h0, bus_ack, bus_atn}, 32'h3);
        loopback_en = 1'b0;
        @(negedge clk);
        issue(mk(0, 1, 0, 0, 0), 32'h0, 1'b0, 32'h0, "R3 clear role");
        chk("R6 ack visible as initiator", {31'h0, bus_ack}, 32'h1);
    endtask

    task automatic t_sequence;
        // start: ack set, atn set; clear atn first
        issue(mk(0, 0, 0, 1, 0), 32'h0, 1'b0, 32'h0, "R10 prep");
        instr_valid = 1'b1; instr_w0 = mk(1, 0, 0, 1, 0);
        @(negedge clk);
        model_apply(instr_w0);
        check_state("R10 atn first");
        chk("R10 ack still set", {30'h0, bus_ack, bus_atn}, 32'h3);
        instr_w0 = mk(0, 0, 1, 0, 0);
        @(negedge clk);
        instr_valid = 1'b0;
        model_apply(instr_w0);
        check_state("R10 ack second");
        chk("R10 final pins", {30'h0, bus_ack, bus_atn}, 32'h1);
        chk("R10 done held", {31'h0, done}, 32'h1);
    endtask

    task automatic t_addr;
        issue(mk(1, 0, 0, 0, 0), 32'hDEADBEEF, 1'b0, 32'h1234, "R7 abs");
        chk("R7 abs addr", next_addr, 32'hDEADBEEF);
        issue(mk(1, 0, 0, 0, 0), 32'h00FFFFF0, 1'b1, 32'h1000, "R8 neg");
        chk("R8 negative offset", next_addr, 32'h00000FF0);
        issue(mk(1, 0, 0, 0, 0), 32'hAB000010, 1'b1, 32'h2000, "R8 pos");
        chk("R8 upper byte ignored", next_addr, 32'h00002010);
        issue(mk(1, 0, 0, 0, 0), 32'h00000020, 1'b1, 32'hFFFFFFF0, "R8 wrap");
        chk("R8 wraparound", next_addr, 32'h00000010);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_role = 0; m_ack = 0; m_atn = 0;
        rst = 1'b1; instr_valid = 1'b0; instr_w0 = '0; instr_w1 = '0;
        rel_mode = 1'b0; script_ptr = '0; loopback_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_assert_both();
        t_reserved();
        t_clear_ack();
        t_role();
        t_sequence();
        t_addr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule